// File: doc/BRIEF.md
# Two-Digit Decimal Down Counter with Preset

This block counts down through the decimal range 00 to 99. It keeps the value as two 4-bit BCD digits, tens above units, and moves one step lower on each rising clock edge while counting is enabled. All of its controls are active-low. A master clear sends the count to 99 at once. An asynchronous preset forces the count to the value on an 8-bit preset bus at once. A synchronous preset takes that value on the next rising edge. A count-inhibit input stops the decrement.

The zero-flag output goes low while the count is 00 and counting is enabled. Several counters are chained by driving the count-inhibit input of the more significant stage from the zero flag of the less significant stage. With two stages the pair counts down through 0000 to 9999. A stage left counting with no preset wraps from 00 to 99, so it runs a repeating sequence of 100 clocks. The block can therefore act as a divide-by-n counter or a programmable interval timer: preset it, then watch the zero flag.

The number of digits is a parameter (default 2). The count value is also brought out as a port.

Top module: `bcd_down_counter`

## Requirements
- R1: While rstN is low, count is 8'h99 at once, with no clock edge, whatever the state of every other input, asyncLoadN included.
- R2: On a rising edge with rstN, asyncLoadN and syncLoadN high and teN low, the count drops by one in decimal. If the units digit was 0 it becomes 9 and the tens digit drops by one.
- R3: While asyncLoadN is low (and rstN is high), count equals presetVal at once, with no clock edge. It stays equal to presetVal across rising edges whatever syncLoadN and teN do.
- R4: When syncLoadN is low (with rstN and asyncLoadN high), count takes presetVal at the next rising edge, even when teN is high. The count does not change before that edge.
- R5: With teN high and no preset active, count holds its value across rising edges.
- R6: tcN is low exactly when count is 8'h00 and teN is low. It follows teN combinationally, with no clock edge.
- R7: From 8'h00, with teN low and no preset active, the next rising edge gives 8'h99. A free-running stage therefore repeats every 100 clocks.
- R8: When a second stage has its teN driven by the first stage's tcN and shares its clock, the pair counts 9999, 9998, … 0000, 9999, one step per clock.
- R9: presetVal[7:4] is the tens digit and presetVal[3:0] is the units digit. A digit above 9 loads unchanged. When that digit is next decremented it becomes 9, and it passes no borrow upward; for example, 8'hAF steps to 8'hA9, and later 8'hA0 steps to 8'h99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous master clear to all-nines, active low |
| asyncLoadN | input | 1 | Asynchronous preset from presetVal, active low |
| syncLoadN | input | 1 | Synchronous preset from presetVal, active low |
| teN | input | 1 | Count enable, active low; high inhibits decrement |
| presetVal | input | 8 | Preset digits, tens in [7:4], units in [3:0] |
| count | output | 8 | Current count, tens in [7:4], units in [3:0] |
| tcN | output | 1 | Zero flag, active low, gated by teN |

## Verification
A wrong digit register shows on count at the first sample after the faulty edge. The zero flag then fires a cycle early or late, or not at all. A fault in the borrow path shows within ten clocks as a units wrap that leaves the tens digit unchanged. A fault in the wrap from 00 shows within one 100-clock cycle. A two-stage cascade swept through all 10,000 states carries any borrow or gating error into the upper stage. There it shows on the upper count at the very cycle the lower stage passes through zero. Preset precedence is checked by driving the two preset controls against the count enable while sampling count both between edges and after them.

// File: rtl/bcd_dn_pkg.sv
package bcd_dn_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_TOP = 4'd9;

  typedef struct packed {
    logic loadJam;
    logic countDn;
  } cnt_strobe_t;

  // A digit at zero, or outside 0..9, steps to nine; any other digit steps down by one.
  function automatic logic [DIGIT_W-1:0] digitDown(input logic [DIGIT_W-1:0] d);
    if (d == '0 || d > DIGIT_TOP) return DIGIT_TOP;
    return d - 1'b1;
  endfunction
endpackage

// File: rtl/bcd_dn_ctrl.sv
module bcd_dn_ctrl
  import bcd_dn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncLoadN,
  input  logic        teN,
  input  logic        isZero,
  output cnt_strobe_t strobes,
  output logic        tcN
);
  // A synchronous preset wins over the decrement, and teN does not block it.
  always_comb begin
    strobes.loadJam = ~syncLoadN;
    strobes.countDn = syncLoadN & ~teN;
  end

  assign tcN = ~(isZero & ~teN);

  AST_TC_GATED: assert property (@(posedge clk) disable iff (!rstN) !tcN |-> !teN); // R6
  AST_TC_ZERO: assert property (@(posedge clk) disable iff (!rstN) !tcN |-> isZero); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN) $onehot0({strobes.loadJam, strobes.countDn})); // R4
endmodule

// File: rtl/bcd_dn_datapath.sv
module bcd_dn_datapath
  import bcd_dn_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  localparam int CW = NUM_DIGITS * DIGIT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          asyncLoadN,
  input  cnt_strobe_t   strobes,
  input  logic [CW-1:0] jam,
  output logic [CW-1:0] cnt,
  output logic          isZero
);
  localparam logic [CW-1:0] CNT_MAX = {NUM_DIGITS{DIGIT_TOP}};

  logic [CW-1:0]       cntNext;
  logic [NUM_DIGITS:0] borrowChain;

  assign borrowChain[0] = 1'b1;

  for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
    logic [DIGIT_W-1:0] cur;
    assign cur = cnt[gi*DIGIT_W +: DIGIT_W];
    assign cntNext[gi*DIGIT_W +: DIGIT_W] = borrowChain[gi] ? digitDown(cur) : cur;
    assign borrowChain[gi+1] = borrowChain[gi] & (cur == '0);
  end

  // A borrow that runs out of the top digit means every digit is zero.
  assign isZero = borrowChain[NUM_DIGITS];

  always_ff @(posedge clk or negedge rstN or negedge asyncLoadN) begin
    if (!rstN)                cnt <= CNT_MAX;
    else if (!asyncLoadN)     cnt <= jam;
    else if (strobes.loadJam) cnt <= jam;
    else if (strobes.countDn) cnt <= cntNext;
  end

  always @(posedge clk) begin
    if (!rstN) AST_RESET_MAX: assert (cnt == CNT_MAX); // R1
  end

  AST_ASYNC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !asyncLoadN |-> cnt == jam); // R3
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (asyncLoadN && strobes.loadJam) |=> (!asyncLoadN || cnt == $past(jam))); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (asyncLoadN && !strobes.loadJam && !strobes.countDn) |=> (!asyncLoadN || $stable(cnt))); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (asyncLoadN && strobes.countDn && isZero) |=> (!asyncLoadN || cnt == CNT_MAX)); // R7
  AST_UNITS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (asyncLoadN && strobes.countDn && cnt[DIGIT_W-1:0] != '0 && cnt[DIGIT_W-1:0] <= DIGIT_TOP)
    |=> (!asyncLoadN || cnt[DIGIT_W-1:0] == $past(cnt[DIGIT_W-1:0]) - 1'b1)); // R2
  AST_UNITS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (asyncLoadN && strobes.countDn) |=> (!asyncLoadN || cnt[DIGIT_W-1:0] <= DIGIT_TOP)); // R9
endmodule

// File: rtl/bcd_down_counter.sv
module bcd_down_counter
  import bcd_dn_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  localparam int CW = NUM_DIGITS * DIGIT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          asyncLoadN,
  input  logic          syncLoadN,
  input  logic          teN,
  input  logic [CW-1:0] presetVal,
  output logic [CW-1:0] count,
  output logic          tcN
);
  cnt_strobe_t strobes;
  logic        isZero;

  bcd_dn_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncLoadN (syncLoadN),
    .teN       (teN),
    .isZero    (isZero),
    .strobes   (strobes),
    .tcN       (tcN)
  );

  bcd_dn_datapath #(.NUM_DIGITS(NUM_DIGITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .asyncLoadN (asyncLoadN),
    .strobes    (strobes),
    .jam        (presetVal),
    .cnt        (count),
    .isZero     (isZero)
  );
endmodule

// File: tb/sim_bcd_down_counter.sv
module sim_bcd_down_counter;
  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic asyncLoadN = 1'b1;
  logic syncLoadN = 1'b1;
  logic teN0 = 1'b1;
  logic [7:0] jam0 = 8'h00;
  logic [7:0] jam1 = 8'h00;
  logic [7:0] count0, count1;
  logic tcN0, tcN1;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  // u0 is the low stage; u1 is enabled by u0's zero flag.
  bcd_down_counter u0 (
    .clk(clk), .rstN(rstN), .asyncLoadN(asyncLoadN), .syncLoadN(syncLoadN),
    .teN(teN0), .presetVal(jam0), .count(count0), .tcN(tcN0)
  );
  bcd_down_counter u1 (
    .clk(clk), .rstN(rstN), .asyncLoadN(asyncLoadN), .syncLoadN(syncLoadN),
    .teN(tcN0), .presetVal(jam1), .count(count1), .tcN(tcN1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] toBcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2 rstN = 1'b0;
    #10;
    chk("R1 reset low stage", count0, 8'h99);
    chk("R1 reset high stage", count1, 8'h99);
    chk("R1 zero flag idle", tcN0, 1'b1);
    jam0 = 8'h12;
    asyncLoadN = 1'b0;
    #3;
    chk("R1 reset over async preset", count0, 8'h99);
    asyncLoadN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;

    // R2 R7 R8: sweep the whole four-digit cascade.
    teN0 = 1'b0;
    #1;
    for (int n = 1; n <= 10000; n++) begin
      int e;
      tick();
      e = 9999 - (n % 10000);
      total++;
      if ({count1, count0} !== {toBcd(e / 100), toBcd(e % 100)} || tcN0 !== ((e % 100) != 0)) begin
        bad++;
        $display("FAIL R2 R7 R8 step %0d actual=%h%h tc=%b expected=%h%h", n, count1, count0, tcN0,
                 toBcd(e / 100), toBcd(e % 100));
      end
    end

    teN0 = 1'b1;
    repeat (5) tick();
    chk("R5 hold with teN high", count0, 8'h99);

    jam0 = 8'h00;
    syncLoadN = 1'b0;
    #1;
    chk("R4 no change before edge", count0, 8'h99);
    tick();
    chk("R4 sync preset despite teN high", count0, 8'h00);
    syncLoadN = 1'b1;
    #1;
    chk("R6 flag gated by teN", tcN0, 1'b1);
    repeat (3) tick();
    chk("R5 hold at zero", count0, 8'h00);
    teN0 = 1'b0;
    #1;
    chk("R6 flag follows teN without clock", tcN0, 1'b0);
    tick();
    chk("R7 wrap to 99", count0, 8'h99);
    chk("R6 flag clears after wrap", tcN0, 1'b1);

    jam0 = 8'h47;
    asyncLoadN = 1'b0;
    #1;
    chk("R3 async preset without edge", count0, 8'h47);
    syncLoadN = 1'b0;
    repeat (2) tick();
    chk("R3 async preset holds over edges", count0, 8'h47);
    asyncLoadN = 1'b1;
    syncLoadN = 1'b1;
    tick();
    chk("R2 decrement after preset", count0, 8'h46);

    jam0 = 8'h30;
    syncLoadN = 1'b0;
    tick();
    chk("R4 sync preset over count", count0, 8'h30);
    syncLoadN = 1'b1;
    tick();
    chk("R2 units borrow", count0, 8'h29);

    jam0 = 8'hAF;
    syncLoadN = 1'b0;
    tick();
    chk("R9 non-decimal digits load as given", count0, 8'hAF);
    syncLoadN = 1'b1;
    tick();
    chk("R9 units above nine step to nine", count0, 8'hA9);
    repeat (9) tick();
    chk("R9 tens kept until borrow", count0, 8'hA0);
    tick();
    chk("R9 tens above nine step to nine", count0, 8'h99);

    jam0 = 8'h5C;
    syncLoadN = 1'b0;
    tick();
    syncLoadN = 1'b1;
    tick();
    chk("R9 no borrow from non-decimal units", count0, 8'h59);

    asyncLoadN = 1'b0;
    #1;
    rstN = 1'b0;
    #1;
    chk("R1 reset while async preset held", count0, 8'h99);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule